// File: doc/BRIEF.md
# NAND Page Read Sequencer with Per-Sector ECC Interleave

This block reads one NAND page as a run of 512-byte sectors. For every sector it sends a read command with the sector's column address and rearms the ECC engine. It then streams the sector data and jumps straight to that sector's 13-byte code slot in the spare area. The ECC engine therefore sees each sector's data followed immediately by its code. After the code the block waits for the engine's ready flag, notes the engine's error count, and signals that the sector can be corrected. It then moves to the next sector.

A request gives a page row address, a sector count (the page size divided by 512) and the bus width. The NAND side is a single operation lane with a valid/ready handshake. Each operation is one of three things: a command byte, an address byte, or one data transfer (a byte on an 8-bit bus, a word on a 16-bit bus). The data itself flows past this block to the ECC engine and the buffer. A programmable cycle limit bounds the wait for the engine. When the limit runs out, the page ends early with an error pulse.

Top module: `nand_sector_reader`

## Requirements
- R1: A request is taken only when `busy` is low, `start` is high and `sector_count` is non-zero. A `start` with a zero count, or a `start` while busy, is ignored. `busy` rises in the cycle after an accepted `start` and stays high up to and including the `page_done` cycle.
- R2: Sector s begins with this data read sequence, in order:
  - CMD 0x00
  - ADDR column low byte, then ADDR column high byte, where the column is s*512
  - ADDR for each row byte, least significant first
  - CMD 0x30
  
  The `op_kind` encoding is 0 for a command, 1 for an address byte and 2 for a data transfer. Data transfer operations carry `op_byte` 0.
- R3: Between the data read sequence and the first data transfer, `ecc_len512` is driven high and `ecc_en` drops for exactly one cycle, then rises again. There is one rising edge of `ecc_en` per sector started. Every data transfer happens with both signals high.
- R4: The sector data phase is 512 transfers on an 8-bit bus (`bus_wide`=0) and 256 transfers on a 16-bit bus.
- R5: After the data of sector s, in a request of more than one sector, the block sends this spare read sequence:
  - CMD 0x50
  - ADDR offset low byte, then ADDR offset high byte, where the offset is 16*s+2
  - the row bytes
  - CMD 0x30
- R6: In a one-sector request, the spare read sequence uses offset 0.
- R7: The spare phase is 13 transfers on an 8-bit bus and 7 transfers on a 16-bit bus.
- R8: After the spare phase the block waits for `ecc_ready`. It then gives a one-cycle `sector_done` with `sector_index` = s. Sectors complete in order.
- R9: Count the wait cycles from 0. If `ecc_ready` is still low in wait cycle number `timeout_limit`, the page ends with a one-cycle pulse on both `page_done` and `timeout_err`. No `sector_done` is given for that sector.
- R10: At `page_done`, `max_flips` holds the largest `ecc_nerr` seen on a correctable sector (count of 8 or less) of this page, and 0 if there is none.
- R11: `page_fail` is set when any sector reports `ecc_nerr` above 8. It stays set until the next accepted request.
- R12: While `op_valid` is high and `op_ready` is low, `op_kind` and `op_byte` hold their values.
- R13: `page_done` pulses in the same cycle as the last sector's `sector_done`, and `busy` is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request pulse |
| page_row | input | 8*ROW_BYTES | Page row address |
| sector_count | input | CNT_W | Sectors in the page |
| bus_wide | input | 1 | 1 selects a 16-bit NAND bus |
| timeout_limit | input | TO_W | Wait limit in cycles for the ECC ready flag |
| op_valid | output | 1 | NAND operation valid |
| op_ready | input | 1 | NAND operation accepted |
| op_kind | output | 2 | 0 command, 1 address, 2 data transfer |
| op_byte | output | 8 | Command or address byte |
| ecc_len512 | output | 1 | ECC engine sector length select |
| ecc_en | output | 1 | ECC engine enable |
| ecc_ready | input | 1 | ECC code ready |
| ecc_nerr | input | 4 | Error count from the engine, above 8 means uncorrectable |
| busy | output | 1 | Request in progress |
| sector_done | output | 1 | Sector ready for correction |
| sector_index | output | CNT_W | Index of the finished sector |
| page_done | output | 1 | Page finished |
| timeout_err | output | 1 | Page ended by timeout |
| max_flips | output | 4 | Largest correctable count in the page |
| page_fail | output | 1 | Sticky uncorrectable flag |

## Verification
The bench keeps the default parameters: three row bytes, a 4-bit sector count and a 16-bit timeout field. It sets `timeout_limit` to 40 at run time. That short limit puts both edges of the timeout window within reach. A ready flag in wait cycle 40 is accepted, and one cycle later the page aborts. The bus width is a run-time input, so both the 13-byte and the 7-word spare phases are exercised. The single-sector offset-0 case and a stalled operation lane are also covered.

// File: rtl/nand_sector_reader.sv
module nand_sector_reader #(
  parameter int ROW_BYTES = 3,
  parameter int CNT_W = 4,
  parameter int TO_W = 16,
  parameter logic [7:0] RD_CMD = 8'h00,
  parameter logic [7:0] OOB_CMD = 8'h50,
  parameter logic [7:0] CONF_CMD = 8'h30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*ROW_BYTES-1:0] page_row,
  input  logic [CNT_W-1:0]       sector_count,
  input  logic                   bus_wide,
  input  logic [TO_W-1:0]        timeout_limit,
  output logic                   op_valid,
  input  logic                   op_ready,
  output logic [1:0]             op_kind,
  output logic [7:0]             op_byte,
  output logic                   ecc_len512,
  output logic                   ecc_en,
  input  logic                   ecc_ready,
  input  logic [3:0]             ecc_nerr,
  output logic                   busy,
  output logic                   sector_done,
  output logic [CNT_W-1:0]       sector_index,
  output logic                   page_done,
  output logic                   timeout_err,
  output logic [3:0]             max_flips,
  output logic                   page_fail
);
  localparam int SECTOR_BYTES = 512;
  localparam int ECC_BYTES = 13;
  localparam int ROW_W = 8 * ROW_BYTES;
  localparam int KW = $clog2(ROW_BYTES + 4);
  localparam int XW = $clog2(SECTOR_BYTES) + 1;
  localparam logic [KW-1:0] K_ROW0 = KW'(3);
  localparam logic [KW-1:0] K_LAST = KW'(ROW_BYTES + 3);
  localparam logic [1:0] K_CMD = 2'd0, K_ADDR = 2'd1, K_READ = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ARM_OFF, S_ARM_ON, S_XFER, S_WAIT, S_SDONE, S_ABORT
  } state_t;

  state_t           st;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q, sec_q;
  logic             wide_q, spare_q;
  logic [KW-1:0]    k_q;
  logic [XW-1:0]    x_q;
  logic [TO_W-1:0]  w_q;

  wire             last_sec = sec_q == cnt_q - 1'b1;
  wire [15:0]      col_data = 16'(sec_q) << 9;
  wire [15:0]      col_spare = (cnt_q == CNT_W'(1)) ? 16'd0 : (16'(sec_q) << 4) + 16'd2;
  wire [15:0]      col = spare_q ? col_spare : col_data;
  wire [KW-1:0]    rsel = k_q - K_ROW0;
  wire [ROW_W-1:0] row_sh = row_q >> {rsel, 3'b000};
  wire [XW-1:0]    x_lim = spare_q ? (wide_q ? XW'((ECC_BYTES + 1) / 2) : XW'(ECC_BYTES))
                                   : (wide_q ? XW'(SECTOR_BYTES / 2) : XW'(SECTOR_BYTES));
  wire             uncorr = ecc_nerr > 4'd8;

  assign busy         = st != S_IDLE;
  assign op_valid     = st == S_CMD || st == S_XFER;
  assign sector_done  = st == S_SDONE;
  assign page_done    = (st == S_SDONE && last_sec) || st == S_ABORT;
  assign timeout_err  = st == S_ABORT;
  assign sector_index = sec_q;

  always_comb begin
    op_kind = K_READ;
    op_byte = 8'h00;
    if (st == S_CMD) begin
      if (k_q == '0) begin
        op_kind = K_CMD;
        op_byte = spare_q ? OOB_CMD : RD_CMD;
      end else if (k_q == K_LAST) begin
        op_kind = K_CMD;
        op_byte = CONF_CMD;
      end else begin
        op_kind = K_ADDR;
        if (k_q == KW'(1))      op_byte = col[7:0];
        else if (k_q == KW'(2)) op_byte = col[15:8];
        else                    op_byte = row_sh[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      row_q <= '0;
      cnt_q <= '0;
      sec_q <= '0;
      wide_q <= 1'b0;
      spare_q <= 1'b0;
      k_q <= '0;
      x_q <= '0;
      w_q <= '0;
      ecc_len512 <= 1'b0;
      ecc_en <= 1'b0;
      max_flips <= '0;
      page_fail <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start && sector_count != '0) begin
            row_q <= page_row;
            cnt_q <= sector_count;
            wide_q <= bus_wide;
            sec_q <= '0;
            spare_q <= 1'b0;
            k_q <= '0;
            max_flips <= '0;
            page_fail <= 1'b0;
            st <= S_CMD;
          end
        S_CMD:
          if (op_ready) begin
            if (k_q == K_LAST) begin
              k_q <= '0;
              x_q <= '0;
              st <= spare_q ? S_XFER : S_ARM_OFF;
            end else begin
              k_q <= k_q + 1'b1;
            end
          end
        S_ARM_OFF: begin
          ecc_len512 <= 1'b1;
          ecc_en <= 1'b0;
          st <= S_ARM_ON;
        end
        S_ARM_ON: begin
          ecc_en <= 1'b1;
          x_q <= '0;
          st <= S_XFER;
        end
        S_XFER:
          if (op_ready) begin
            if (x_q == x_lim - 1'b1) begin
              x_q <= '0;
              w_q <= '0;
              if (spare_q) st <= S_WAIT;
              else begin
                spare_q <= 1'b1;
                k_q <= '0;
                st <= S_CMD;
              end
            end else begin
              x_q <= x_q + 1'b1;
            end
          end
        S_WAIT:
          if (ecc_ready) begin
            if (uncorr) page_fail <= 1'b1;
            else if (ecc_nerr > max_flips) max_flips <= ecc_nerr;
            st <= S_SDONE;
          end else if (w_q == timeout_limit) begin
            st <= S_ABORT;
          end else begin
            w_q <= w_q + 1'b1;
          end
        S_SDONE:
          if (last_sec) st <= S_IDLE;
          else begin
            sec_q <= sec_q + 1'b1;
            spare_q <= 1'b0;
            k_q <= '0;
            st <= S_CMD;
          end
        S_ABORT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_sector_reader_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] sector_count,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_kind,
  input logic [7:0]       op_byte,
  input logic             ecc_len512,
  input logic             ecc_en,
  input logic             busy,
  input logic             sector_done,
  input logic             page_done,
  input logic             timeout_err,
  input logic [3:0]       max_flips,
  input logic             page_fail
);
  assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sector_count != '0) |=> busy);
  assert_rearm_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ecc_en) |=> ecc_en);
  assert_read_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd2) |-> (ecc_en && ecc_len512));
  assert_timeout_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (page_done && !sector_done));
  assert_max_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    max_flips <= 4'd8);
  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$fell(page_fail));
  assert_op_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_byte)));
  assert_done_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> busy);
  assert_idle_after_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !busy);
endmodule

bind nand_sector_reader nand_sector_reader_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/nand_sector_reader_tb.sv
module nand_sector_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] page_row = '0;
  logic [3:0] sector_count = '0;
  logic bus_wide = 1'b0;
  logic [15:0] timeout_limit = 16'd40;
  logic op_valid, op_ready, ecc_len512, ecc_en, ecc_ready;
  logic [1:0] op_kind;
  logic [7:0] op_byte;
  logic [3:0] ecc_nerr;
  logic busy, sector_done, page_done, timeout_err, page_fail;
  logic [3:0] sector_index, max_flips;

  always #5 clk = ~clk;

  nand_sector_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_row(page_row),
    .sector_count(sector_count), .bus_wide(bus_wide), .timeout_limit(timeout_limit),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_byte(op_byte),
    .ecc_len512(ecc_len512), .ecc_en(ecc_en), .ecc_ready(ecc_ready), .ecc_nerr(ecc_nerr),
    .busy(busy), .sector_done(sector_done), .sector_index(sector_index),
    .page_done(page_done), .timeout_err(timeout_err), .max_flips(max_flips),
    .page_fail(page_fail));

  int errors = 0, checks = 0;
  logic [9:0] q_op[$];
  string q_tag[$];
  int q_sd[$];
  int dly_tab[16], nerr_tab[16];
  int data_n = 512, spare_n = 13;
  bit stall_mode = 0;
  int rd_cnt = 0, ecc_sec = 0, arm_sec = 0, dly = 0, cyc = 0, rises = 0;
  bit armed = 0, en_prev = 0, pd_seen = 0;
  bit got_to, got_fail, got_busy;
  int got_max;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b, input string tag);
    q_op.push_back({k, b});
    q_tag.push_back(tag);
  endtask

  // monitor and ECC engine model, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      ecc_ready = 1'b0;
      ecc_nerr = 4'd0;
      op_ready = 1'b1;
    end else begin
      ecc_ready = 1'b0;
      if (armed) begin
        if (dly == 0) begin
          ecc_ready = 1'b1;
          ecc_nerr = 4'(nerr_tab[arm_sec]);
          armed = 0;
        end else dly--;
      end
      cyc++;
      op_ready = stall_mode ? (cyc % 3 != 2) : 1'b1;
      if (op_valid && op_ready) begin
        if (q_op.size() == 0) begin
          check(0, "R2", "unexpected operation", {op_kind, op_byte}, -1);
        end else begin
          logic [9:0] e;
          string t;
          e = q_op.pop_front();
          t = q_tag.pop_front();
          check({op_kind, op_byte} == e, t, "operation", {op_kind, op_byte}, e);
          if (op_kind == 2'd2 && t == "R4")
            check(ecc_en && ecc_len512, "R3", "engine armed on data", {ecc_en, ecc_len512}, 3);
        end
        if (op_kind == 2'd2) begin
          rd_cnt++;
          if (rd_cnt == data_n + spare_n) begin
            rd_cnt = 0;
            armed = 1;
            dly = dly_tab[ecc_sec];
            arm_sec = ecc_sec;
            ecc_sec++;
          end
        end
      end
      if (sector_done) begin
        if (q_sd.size() == 0) check(0, "R8", "unexpected sector_done", sector_index, -1);
        else begin
          int s;
          s = q_sd.pop_front();
          check(sector_index == 4'(s), "R8", "sector_index", sector_index, s);
        end
      end
      if (ecc_en && !en_prev) rises++;
      en_prev = ecc_en;
      if (page_done) begin
        got_to = timeout_err;
        got_max = max_flips;
        got_fail = page_fail;
        got_busy = busy;
        pd_seen = 1;
      end
    end
  end

  task automatic run_page(input logic [23:0] pg, input int cnt, input bit wide,
                          input bit stall, input int to_sec, input bit poke);
    int last, exp_max, armed_n;
    bit exp_fail;
    data_n = wide ? 256 : 512;
    spare_n = wide ? 7 : 13;
    stall_mode = stall;
    exp_max = 0;
    exp_fail = 0;
    last = (to_sec >= 0) ? to_sec : cnt - 1;
    armed_n = last + 1;
    for (int s = 0; s <= last; s++) begin
      int col, off;
      string st;
      col = s * 512;
      push(2'd0, 8'h00, "R2");
      push(2'd1, 8'(col), "R2");
      push(2'd1, 8'(col >> 8), "R2");
      for (int r = 0; r < 3; r++) push(2'd1, pg[8*r +: 8], "R2");
      push(2'd0, 8'h30, "R2");
      for (int i = 0; i < data_n; i++) push(2'd2, 8'h00, "R4");
      off = (cnt == 1) ? 0 : 16 * s + 2;
      st = (cnt == 1) ? "R6" : "R5";
      push(2'd0, 8'h50, st);
      push(2'd1, 8'(off), st);
      push(2'd1, 8'(off >> 8), st);
      for (int r = 0; r < 3; r++) push(2'd1, pg[8*r +: 8], st);
      push(2'd0, 8'h30, st);
      for (int i = 0; i < spare_n; i++) push(2'd2, 8'h00, "R7");
      if (s != to_sec) begin
        q_sd.push_back(s);
        if (nerr_tab[s] > 8) exp_fail = 1;
        else if (nerr_tab[s] > exp_max) exp_max = nerr_tab[s];
      end
    end
    rd_cnt = 0; ecc_sec = 0; armed = 0; rises = 0; pd_seen = 0;
    @(negedge clk);
    start = 1'b1; page_row = pg; sector_count = 4'(cnt); bus_wide = wide;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; page_row = 24'hFFFFFF; sector_count = 4'd1; bus_wide = ~wide;
      @(negedge clk);
      start = 1'b0; bus_wide = wide;
      check(busy == 1'b1, "R1", "start while busy ignored", busy, 1);
    end
    while (!pd_seen) @(negedge clk);
    check(got_to == (to_sec >= 0), "R9", "timeout_err", got_to, to_sec >= 0);
    check(got_max == exp_max, "R10", "max_flips", got_max, exp_max);
    check(got_fail == exp_fail, "R11", "page_fail", got_fail, exp_fail);
    check(got_busy == 1'b1, "R13", "busy during page_done", got_busy, 1);
    check(q_op.size() == 0, "R2", "operations left", q_op.size(), 0);
    check(q_sd.size() == 0, "R8", "sector_done missing", q_sd.size(), 0);
    check(rises == armed_n, "R3", "ecc_en rearm count", rises, armed_n);
    @(negedge clk);
    check(busy == 1'b0, "R13", "busy after page_done", busy, 0);
    q_op.delete(); q_tag.delete(); q_sd.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && op_valid == 0 && ecc_en == 0 && page_done == 0, "R1", "reset state",
          {busy, op_valid, ecc_en, page_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // four sectors, 8-bit bus, varied delays and counts
    dly_tab[0] = 0; dly_tab[1] = 3; dly_tab[2] = 7; dly_tab[3] = 2;
    nerr_tab[0] = 0; nerr_tab[1] = 5; nerr_tab[2] = 2; nerr_tab[3] = 8;
    run_page(24'h0A0B0C, 4, 0, 0, -1, 0);
    // single sector on 16-bit bus: spare offset 0, 7 words (R6, R7)
    dly_tab[0] = 1; nerr_tab[0] = 3;
    run_page(24'h123456, 1, 1, 0, -1, 0);
    // stalled lane, uncorrectable first sector, ignored start (R11, R12, R1)
    dly_tab[0] = 4; dly_tab[1] = 0; nerr_tab[0] = 9; nerr_tab[1] = 1;
    run_page(24'hA5C3E1, 2, 1, 1, -1, 1);
    // ready in the last allowed wait cycle; flags cleared by new request (R9, R11)
    dly_tab[0] = 0; dly_tab[1] = 40; dly_tab[2] = 0;
    nerr_tab[0] = 2; nerr_tab[1] = 0; nerr_tab[2] = 4;
    run_page(24'h000102, 3, 0, 0, -1, 0);
    // one cycle too late: timeout on sector 1 (R9)
    dly_tab[1] = 41; nerr_tab[0] = 6;
    run_page(24'h7F8081, 3, 0, 0, 1, 0);
    // zero count is ignored (R1)
    @(negedge clk);
    start = 1'b1; sector_count = 4'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0 && op_valid == 0, "R1", "zero-count start ignored", {busy, op_valid}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule